// File: doc/BRIEF.md
# Configuration Image Integrity Checker

This block checks a fixed-length configuration image while it streams past, one byte in each cycle where the byte-valid input is high. It keeps a small header, runs a 16-bit additive sum over the body, compares the closing bytes against a fixed signature, and gives one verdict when the last byte arrives. It does not fetch the bytes and does not correct anything. The image length is the parameter `IMG_LEN`, which must be at least 13.

Layout, with byte index `i` counted from 0 after the start strobe. Bytes 0..1 hold a 16-bit type word, least-significant byte first. Bytes 2..3 hold a 16-bit byte count and bytes 4..5 a 16-bit checksum, both in the same byte order. Bytes 6..`IMG_LEN`-7 form the summed body. The last six bytes form the signature.

A start strobe rewinds the block before each image. The verdict is a one-cycle `done` pulse together with a 2-bit `reason`. The `reason` value stays on the port until the next verdict replaces it.

Top module: `nvimg_checker`

## Requirements
- R1: If the type word (byte 0 low, byte 1 high) is not zero, the verdict reason is 1.
- R2: If the byte count (byte 2 low, byte 3 high) is not equal to `IMG_LEN`-12, the verdict reason is 2.
- R3: The 16-bit sum of the bytes at indices 6 through `IMG_LEN`-7 must equal the stored checksum (byte 4 low, byte 5 high). On a mismatch the verdict reason is 3.
- R4: The last six bytes must be 0xFE, 0xFE, 0x00, 0x00, 0x00, 0x00 in that order. A mismatch at any position gives verdict reason 3.
- R5: An image that passes every check gives verdict reason 0.
- R6: When several checks fail, the reported reason follows this priority: type (1) first, then count (2), then checksum or signature (3).
- R7: `done` is high for exactly one cycle, in the cycle after the clock edge that accepts byte `IMG_LEN`-1. `reason` changes only together with `done` and holds between verdicts.
- R8: A start strobe rewinds the byte index, the sum and the signature state. A byte presented in the same cycle as the strobe is dropped. A strobe in the middle of an image abandons that image with no verdict.
- R9: A cycle with byte-valid low does not advance the image. Bytes after the last one of an image are ignored until the next strobe and give no further verdict.
- R10: After a synchronous reset, `done` is 0 and `reason` is 0.
- R11: The body sum wraps modulo 2^16, and the carry out is discarded (no end-around add).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| img_start | input | 1 | Start-of-image strobe; rewinds the checker |
| byte_vld | input | 1 | Image byte valid this cycle |
| byte_data | input | 8 | Image byte |
| done | output | 1 | One-cycle verdict pulse |
| reason | output | 2 | 0 ok, 1 type, 2 count, 3 checksum or signature |

## Verification
The embedded assertions check on every cycle that the byte index never passes the image length, that a strobe clears the index and the sum, that the sum stays unchanged outside the body window, that a signature miss stays latched, and that `done` never lasts two cycles while `reason` only moves with a verdict. Only the bench scenarios can show the verdict values themselves. These cover single and combined field failures, each of the six signature positions, a body whose sum wraps past 16 bits, restarts in the middle of an image, strobes that coincide with a byte, idle gaps, and surplus bytes after the end of an image.

// File: rtl/nvimg_pkg.sv
// Shared definitions for the configuration image checker.
// Assumes the image is at least 13 bytes so header and signature never overlap.
package nvimg_pkg;

    typedef enum logic [1:0] {
        RSN_OK    = 2'd0,
        RSN_TYPE  = 2'd1,
        RSN_COUNT = 2'd2,
        RSN_SUM   = 2'd3
    } reason_e;

    localparam int HDR_BYTES = 6;
    localparam int SIG_BYTES = 6;

    // Expected signature byte at offset k within the closing bytes.
    function automatic logic [7:0] sig_byte(input int unsigned k);
        return (k < 2) ? 8'hFE : 8'h00;
    endfunction

endpackage

// File: rtl/nvimg_position.sv
// Byte index tracker: counts accepted bytes of the current image.
// Assumes img_start has priority over byte_vld; the index saturates at IMG_LEN.
module nvimg_position #(
    parameter int IMG_LEN = 300,
    parameter int IDX_W   = $clog2(IMG_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             img_start,
    input  logic             byte_vld,
    output logic [IDX_W-1:0] idx,
    output logic             accept,
    output logic             last
);

    // Accept a byte only outside a strobe and while the image is not complete.
    always_comb begin
        accept = byte_vld && !img_start && (idx < IDX_W'(IMG_LEN));
        last   = accept && (idx == IDX_W'(IMG_LEN - 1));
    end

    // Advance the index on each accepted byte; rewind on strobe or reset.
    always_ff @(posedge clk) begin
        if (!rst_n)         idx <= '0;
        else if (img_start) idx <= '0;
        else if (accept)    idx <= idx + 1'b1;
    end

    p_idx_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= IDX_W'(IMG_LEN));

    p_start_rewinds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        img_start |=> (idx == '0));

endmodule

// File: rtl/nvimg_fields.sv
// Header capture and signature comparison.
// Stores bytes 0..5 as they pass and latches a miss on any closing byte that
// differs from the fixed signature. cur_miss flags a miss on the byte in flight.
module nvimg_fields
    import nvimg_pkg::*;
#(
    parameter int IMG_LEN = 300,
    parameter int IDX_W   = $clog2(IMG_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             img_start,
    input  logic             accept,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       byte_data,
    output logic [15:0]      type_w,
    output logic [15:0]      count_w,
    output logic [15:0]      csum_w,
    output logic             sig_miss,
    output logic             cur_miss
);

    localparam int SIG_FIRST = IMG_LEN - SIG_BYTES;

    // One capture register for each header byte position.
    for (genvar k = 0; k < HDR_BYTES; k++) begin : g_hdr
        logic [7:0] b_q;
        // Hold header byte k once its index passes.
        always_ff @(posedge clk) begin
            if (!rst_n)                               b_q <= 8'h00;
            else if (accept && idx == IDX_W'(k))      b_q <= byte_data;
        end
    end

    // Assemble the little-endian header words.
    always_comb begin
        type_w  = {g_hdr[1].b_q, g_hdr[0].b_q};
        count_w = {g_hdr[3].b_q, g_hdr[2].b_q};
        csum_w  = {g_hdr[5].b_q, g_hdr[4].b_q};
    end

    logic             in_sig;
    logic [IDX_W-1:0] sig_pos;

    // Compare the byte in flight against the signature when in the closing window.
    always_comb begin
        in_sig   = (idx >= IDX_W'(SIG_FIRST));
        sig_pos  = idx - IDX_W'(SIG_FIRST);
        cur_miss = accept && in_sig &&
                   (byte_data != sig_byte(32'(sig_pos)));
    end

    // Latch any signature miss until the next strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         sig_miss <= 1'b0;
        else if (img_start) sig_miss <= 1'b0;
        else if (cur_miss)  sig_miss <= 1'b1;
    end

    p_sig_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_miss && !img_start) |=> sig_miss);

endmodule

// File: rtl/nvimg_sum.sv
// Body accumulator: 16-bit wrapping sum of the bytes at indices
// 6 .. IMG_LEN-7. The carry out is dropped; a strobe clears the sum.
module nvimg_sum
    import nvimg_pkg::*;
#(
    parameter int IMG_LEN = 300,
    parameter int IDX_W   = $clog2(IMG_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             img_start,
    input  logic             accept,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       byte_data,
    output logic [15:0]      sum
);

    localparam int WIN_LO = HDR_BYTES;
    localparam int WIN_HI = IMG_LEN - SIG_BYTES - 1;

    logic in_win;

    // Decide whether the accepted byte belongs to the body.
    always_comb in_win = (idx >= IDX_W'(WIN_LO)) && (idx <= IDX_W'(WIN_HI));

    // Add body bytes modulo 2^16.
    always_ff @(posedge clk) begin
        if (!rst_n)                sum <= 16'h0000;
        else if (img_start)        sum <= 16'h0000;
        else if (accept && in_win) sum <= sum + {8'h00, byte_data};
    end

    p_sum_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        img_start |=> (sum == 16'h0000));

    p_sum_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!img_start && !(accept && in_win)) |=> $stable(sum));

endmodule

// File: rtl/nvimg_checker.sv
// Top level: streams a configuration image, checks type, byte count,
// body checksum and signature, and pulses a verdict after the last byte.
// Assumes IMG_LEN >= 13 so all header bytes are in before the last byte.
module nvimg_checker
    import nvimg_pkg::*;
#(
    parameter int IMG_LEN = 300
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       img_start,
    input  logic       byte_vld,
    input  logic [7:0] byte_data,
    output logic       done,
    output logic [1:0] reason
);

    localparam int IDX_W = $clog2(IMG_LEN + 1);
    localparam logic [15:0] COUNT_EXP = 16'(IMG_LEN - 12);

    logic [IDX_W-1:0] idx;
    logic             accept;
    logic             last;
    logic [15:0]      type_w, count_w, csum_w, sum;
    logic             sig_miss, cur_miss;
    reason_e          pick;

    nvimg_position #(.IMG_LEN(IMG_LEN), .IDX_W(IDX_W)) u_pos (
        .clk(clk), .rst_n(rst_n), .img_start(img_start), .byte_vld(byte_vld),
        .idx(idx), .accept(accept), .last(last)
    );

    nvimg_fields #(.IMG_LEN(IMG_LEN), .IDX_W(IDX_W)) u_fields (
        .clk(clk), .rst_n(rst_n), .img_start(img_start), .accept(accept),
        .idx(idx), .byte_data(byte_data), .type_w(type_w), .count_w(count_w),
        .csum_w(csum_w), .sig_miss(sig_miss), .cur_miss(cur_miss)
    );

    nvimg_sum #(.IMG_LEN(IMG_LEN), .IDX_W(IDX_W)) u_sum (
        .clk(clk), .rst_n(rst_n), .img_start(img_start), .accept(accept),
        .idx(idx), .byte_data(byte_data), .sum(sum)
    );

    // Choose the reason by fixed priority: type, count, then checksum/signature.
    always_comb begin
        if (type_w != 16'h0000)                     pick = RSN_TYPE;
        else if (count_w != COUNT_EXP)              pick = RSN_COUNT;
        else if (sum != csum_w || sig_miss || cur_miss) pick = RSN_SUM;
        else                                        pick = RSN_OK;
    end

    // Register the verdict on the last byte; reason holds until the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            reason <= RSN_OK;
        end else begin
            done <= last;
            if (last) reason <= pick;
        end
    end

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_reason_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (reason == $past(reason)) || $past(!rst_n));

endmodule

// File: tb/nvimg_checker_test.sv
// Bench: behavioural reference model (queue of accepted bytes) compared on
// every clock, plus directed verdict checks per requirement.
module nvimg_checker_test;

    localparam int LEN = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       img_start = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       done;
    logic [1:0] reason;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    string cur_req = "R10";

    int img [LEN];

    nvimg_checker #(.IMG_LEN(LEN)) uut (
        .clk(clk), .rst_n(rst_n), .img_start(img_start), .byte_vld(byte_vld),
        .byte_data(byte_data), .done(done), .reason(reason)
    );

    always #5 clk = ~clk;

    // ---------------- reference model ----------------
    logic [7:0] mq [$];
    bit  m_done = 0;
    int  m_reason = 0;

    function automatic int judge();
        int t, c, s, acc;
        bit sig_ok;
        t = mq[0] + 256 * mq[1];
        c = mq[2] + 256 * mq[3];
        s = mq[4] + 256 * mq[5];
        acc = 0;
        for (int i = 6; i <= LEN - 7; i++) acc = (acc + mq[i]) % 65536;
        sig_ok = (mq[LEN-6] == 8'hFE) && (mq[LEN-5] == 8'hFE) &&
                 (mq[LEN-4] == 0) && (mq[LEN-3] == 0) &&
                 (mq[LEN-2] == 0) && (mq[LEN-1] == 0);
        if (t != 0) return 1;
        if (c != LEN - 12) return 2;
        if (acc != s || !sig_ok) return 3;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_done = 0;
            m_reason = 0;
        end else begin
            m_done = 0;
            if (img_start) mq.delete();
            else if (byte_vld && mq.size() < LEN) begin
                mq.push_back(byte_data);
                if (mq.size() == LEN) begin
                    m_done = 1;
                    m_reason = judge();
                end
            end
        end
    end

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            n_vec++;
            if (done !== m_done || reason !== 2'(m_reason)) begin
                n_bad++;
                $display("FAIL %s: done=%0b reason=%0d expected done=%0b reason=%0d",
                         cur_req, done, reason, m_done, m_reason);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: cycles=%0d expected below 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // ---------------- helpers ----------------
    function automatic int body_sum();
        int acc = 0;
        for (int i = 6; i <= LEN - 7; i++) acc = (acc + img[i]) % 65536;
        return acc;
    endfunction

    task automatic make_good(input int seed, input bit all_ff);
        for (int i = 6; i <= LEN - 7; i++)
            img[i] = all_ff ? 255 : ((i * seed + 7) % 256);
        img[LEN-6] = 8'hFE; img[LEN-5] = 8'hFE;
        for (int k = 4; k >= 1; k--) img[LEN-k] = 0;
        img[0] = 0; img[1] = 0;
        img[2] = (LEN - 12) % 256; img[3] = (LEN - 12) / 256;
        img[4] = body_sum() % 256; img[5] = body_sum() / 256;
    endtask

    task automatic strobe(input bit with_byte);
        img_start = 1'b1;
        byte_vld  = with_byte;
        byte_data = 8'h55;
        @(negedge clk);
        img_start = 1'b0;
        byte_vld  = 1'b0;
    endtask

    task automatic send(input int gap, input int upto);
        strobe(1'b0);
        for (int i = 0; i < upto; i++) begin
            if (gap != 0 && i % gap == 0) begin
                byte_vld = 1'b0;
                @(negedge clk);
            end
            byte_vld  = 1'b1;
            byte_data = img[i][7:0];
            @(negedge clk);
        end
        byte_vld = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic expect_reason(input int exp, input string req);
        n_vec++;
        if (reason !== 2'(exp)) begin
            n_bad++;
            $display("FAIL %s: reason=%0d expected=%0d", req, reason, exp);
        end
    endtask

    // ---------------- scenarios ----------------
    initial begin
        repeat (2) @(negedge clk);
        // R10: reset state
        n_vec++;
        if (done !== 1'b0 || reason !== 2'd0) begin
            n_bad++;
            $display("FAIL R10: done=%0b reason=%0d expected done=0 reason=0", done, reason);
        end
        rst_n = 1'b1;
        @(negedge clk);

        cur_req = "R5"; make_good(3, 0); send(0, LEN); expect_reason(0, "R5");
        cur_req = "R9"; make_good(5, 0); send(7, LEN); expect_reason(0, "R9");

        cur_req = "R1"; make_good(11, 0); img[1] = 1; send(0, LEN); expect_reason(1, "R1");
        cur_req = "R2"; make_good(13, 0); img[2] ^= 1; send(0, LEN); expect_reason(2, "R2");
        cur_req = "R3"; make_good(17, 0); img[4] ^= 1; send(0, LEN); expect_reason(3, "R3");
        cur_req = "R3"; make_good(17, 0); img[100] ^= 8'h80; send(0, LEN); expect_reason(3, "R3");

        cur_req = "R4";
        for (int k = 0; k < 6; k++) begin
            make_good(19 + k, 0);
            img[LEN-6+k] ^= 8'h01;
            send(0, LEN);
            expect_reason(3, "R4");
        end

        cur_req = "R6"; make_good(23, 0); img[0] = 4; img[3] = 9; img[LEN-1] = 1;
        send(0, LEN); expect_reason(1, "R6");
        cur_req = "R6"; make_good(29, 0); img[3] = 9; img[LEN-2] = 1;
        send(0, LEN); expect_reason(2, "R6");

        // R11: body of all 0xFF wraps; stored checksum 288*255 mod 65536 = 7904
        cur_req = "R11"; make_good(1, 1);
        n_vec++;
        if (img[4] + 256 * img[5] != 7904) begin
            n_bad++;
            $display("FAIL R11: stored=%0d expected=7904", img[4] + 256 * img[5]);
        end
        send(0, LEN); expect_reason(0, "R11");

        // R8: abandon a half image, then a full bad-type image, then a good one
        cur_req = "R8"; make_good(31, 0); send(0, LEN / 2);
        img[0] = 1; send(0, LEN); expect_reason(1, "R8");
        make_good(37, 0); send(0, LEN / 2); send(0, LEN); expect_reason(0, "R8");

        // R8: byte in the strobe cycle is dropped
        cur_req = "R8"; make_good(41, 0);
        strobe(1'b1);
        for (int i = 0; i < LEN; i++) begin
            byte_vld = 1'b1; byte_data = img[i][7:0]; @(negedge clk);
        end
        byte_vld = 1'b0; repeat (2) @(negedge clk);
        expect_reason(0, "R8");

        // R9: surplus bytes after completion give no further verdict
        cur_req = "R9"; make_good(43, 0); send(0, LEN);
        for (int i = 0; i < 20; i++) begin
            byte_vld = 1'b1; byte_data = 8'hAA; @(negedge clk);
        end
        byte_vld = 1'b0; repeat (2) @(negedge clk);
        expect_reason(0, "R9");

        cur_req = "R7"; make_good(47, 0); img[1] = 2; send(3, LEN); expect_reason(1, "R7");

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule